// File: doc/BRIEF.md
# Vector Indexed Register Move Engine

This block performs an index-driven register-to-register vector move over its own small register file. A caller supplies three base register numbers, a vector length and one option bit, then pulses a start strobe. For each element position `i` from 0 up to the length minus one, the engine does three things in order:

- It fetches an index value from the index vector.
- It validates that index.
- It copies the selected element of the source vector into destination position `i`.

The index picks the source element, not the destination slot. Repeated indices therefore replicate a source element into several destination slots. The engine handles one element per clock cycle, in increasing element order.

The engine rejects bad requests before any element runs. If any of the three vectors would extend past the last register, the request traps and nothing is written. At run time, an index that is not below the vector length traps at that element. Processing stops there, and elements written earlier stay written. When the option bit is set, an index whose bits are all ones is not an error: it writes zero to its destination element instead. There is no streaming data path. Start, the operand fields, busy, done and trap are plain control and status pins. A test write port and a test read port give access to the register file while the engine is idle.

Top module: `vimv_top`

## Requirements
- R1: After reset, `busy`, `done` and `trap` are low, `trap_elem` is 0, and every register reads as zero through the test read port.
- R2: When start is accepted with a valid request of length VL ≥ 1, the engine does the following:
  - For each i < VL, it writes reg[dst_base+i] = reg[src_base+reg[idx_base+i]].
  - It processes one element per cycle, in increasing i.
  - `busy` is high while elements run.
  - `done` is high in the cycle after the last write, which is VL+1 cycles after the start edge.
- R3: Index values may repeat. Each destination element receives the source element its own index selects, so source elements are replicated.
- R4: An index that is not below VL, compared as an unsigned 64-bit value, traps at element k:
  - Element k and all later elements are not written.
  - Elements below k keep their new values.
  - `trap` rises with `done`, k+2 cycles after the start edge, and `trap_elem` equals k.
- R5: With `zero_neg1`=1, an index of all ones (-1) writes zero to its destination element. With `zero_neg1`=0, the same index traps as in R4.
- R6: If `dst_base`+VL, `src_base`+VL or `idx_base`+VL exceeds 32:
  - The request traps with `done` one cycle after the start edge.
  - `busy` never rises, no register is written, and `trap_elem` is 0.
  - A vector that ends exactly at register 31 is legal.
- R7: A request with VL=0 completes with `done` one cycle after the start edge, with no trap and no write.
- R8: Element i reads its index and source registers after element i-1 has been written, so overlapping vectors behave as a strictly sequential loop.
- R9: A start pulse while `busy` is high is ignored.
- R10: `done` is a one-cycle pulse. `trap` stays high until the next accepted start and is low while `busy` is high.
- R11: The test write port writes only while the engine is idle; while `busy` is high it is ignored. The test read port returns register contents while idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start strobe, accepted only when idle |
| dst_base | input | 5 | First register of the destination vector |
| src_base | input | 5 | First register of the source vector |
| idx_base | input | 5 | First register of the index vector |
| vlen | input | 6 | Vector length, 0 to 32 |
| zero_neg1 | input | 1 | An index of all ones writes zero instead of trapping |
| busy | output | 1 | Elements are being processed |
| done | output | 1 | One-cycle completion pulse |
| trap | output | 1 | Last request trapped; held until the next start |
| trap_elem | output | 5 | Element number that trapped |
| tw_en | input | 1 | Test write enable (idle only) |
| tw_addr | input | 5 | Test write register number |
| tw_data | input | 64 | Test write data |
| dbg_addr | input | 5 | Test read register number |
| dbg_data | output | 64 | Test read data, valid while idle |

## Verification
The core move is driven with four index patterns:

- A permutation shows that the index selects the source, not the destination.
- A pattern with repeated values shows that source elements are replicated.
- A chain in which the destination overlaps the source, offset by one, separates sequential semantics from a snapshot of the source taken before the loop.
- A pattern with an out-of-range value in the middle shows that earlier writes are kept and later ones are suppressed.

The all-ones index is run with the option bit both set and clear. Span checks are run on an exact fit and on an overrun by one. Zero length is run on its own.

// File: rtl/vimv_pkg.sv
package vimv_pkg;
  localparam int NREGS_DEF = 32;
  localparam int XLEN_DEF  = 64;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } vimv_state_e;
endpackage

// File: rtl/vimv_rf.sv
module vimv_rf #(
  parameter int NREGS = vimv_pkg::NREGS_DEF,
  parameter int XLEN  = vimv_pkg::XLEN_DEF,
  localparam int AW   = $clog2(NREGS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   ra_addr,
  output logic [XLEN-1:0] ra_data,
  input  logic [AW-1:0]   rb_addr,
  output logic [XLEN-1:0] rb_data,
  input  logic            we,
  input  logic [AW-1:0]   wa,
  input  logic [XLEN-1:0] wd
);
  logic [XLEN-1:0] regs [NREGS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < NREGS; r++) regs[r] <= '0;
    end else if (we) begin
      regs[wa] <= wd;
    end
  end

  // Reads see the state before this cycle's write.
  assign ra_data = regs[ra_addr];
  assign rb_data = regs[rb_addr];
endmodule

// File: rtl/vimv_seq.sv
module vimv_seq #(
  parameter int NREGS = vimv_pkg::NREGS_DEF,
  parameter int XLEN  = vimv_pkg::XLEN_DEF,
  localparam int AW   = $clog2(NREGS),
  localparam int LW   = AW + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [AW-1:0]   dst_base,
  input  logic [AW-1:0]   src_base,
  input  logic [AW-1:0]   idx_base,
  input  logic [LW-1:0]   vlen,
  input  logic            zero_neg1,
  input  logic [XLEN-1:0] idx_val,
  input  logic [XLEN-1:0] src_val,
  output logic [AW-1:0]   idx_addr,
  output logic [AW-1:0]   src_addr,
  output logic            we,
  output logic [AW-1:0]   wa,
  output logic [XLEN-1:0] wd,
  output logic            busy,
  output logic            done,
  output logic            trap,
  output logic [AW-1:0]   trap_elem
);
  import vimv_pkg::*;

  vimv_state_e     state;
  logic [AW-1:0]   elem;
  logic [AW-1:0]   dst_r, src_r, idx_r;
  logic [LW-1:0]   vl_r;
  logic            zen_r;
  logic            done_q, trap_q;
  logic [AW-1:0]   trap_elem_q;

  logic            span_bad;
  logic            in_rng, all_ones, zero_el, el_ok, last;

  // Span check over all three vectors at request time.
  always_comb begin
    logic [AW-1:0] bases [3];
    logic [LW:0]   span;
    bases[0] = dst_base;
    bases[1] = src_base;
    bases[2] = idx_base;
    span_bad = 1'b0;
    for (int b = 0; b < 3; b++) begin
      span = {2'b00, bases[b]} + {1'b0, vlen};
      if (span > (LW+1)'(NREGS)) span_bad = 1'b1;
    end
  end

  // Single-cycle element datapath: index read, check, source read, write.
  always_comb begin
    idx_addr = idx_r + elem;
    in_rng   = idx_val < XLEN'(vl_r);
    all_ones = &idx_val;
    zero_el  = zen_r && all_ones;
    el_ok    = in_rng || zero_el;
    src_addr = src_r + idx_val[AW-1:0];
    wa       = dst_r + elem;
    wd       = zero_el ? '0 : src_val;
    we       = (state == ST_RUN) && el_ok;
    last     = ({1'b0, elem} == vl_r - LW'(1));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      elem        <= '0;
      dst_r       <= '0;
      src_r       <= '0;
      idx_r       <= '0;
      vl_r        <= '0;
      zen_r       <= 1'b0;
      done_q      <= 1'b0;
      trap_q      <= 1'b0;
      trap_elem_q <= '0;
    end else begin
      done_q <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            trap_q      <= 1'b0;
            trap_elem_q <= '0;
            dst_r       <= dst_base;
            src_r       <= src_base;
            idx_r       <= idx_base;
            vl_r        <= vlen;
            zen_r       <= zero_neg1;
            elem        <= '0;
            if (span_bad) begin
              done_q <= 1'b1;
              trap_q <= 1'b1;
            end else if (vlen == '0) begin
              done_q <= 1'b1;
            end else begin
              state <= ST_RUN;
            end
          end
        end
        ST_RUN: begin
          if (!el_ok) begin
            trap_q      <= 1'b1;
            trap_elem_q <= elem;
            done_q      <= 1'b1;
            state       <= ST_IDLE;
          end else if (last) begin
            done_q <= 1'b1;
            state  <= ST_IDLE;
          end else begin
            elem <= elem + AW'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy      = (state == ST_RUN);
  assign done      = done_q;
  assign trap      = trap_q;
  assign trap_elem = trap_elem_q;
endmodule

// File: rtl/vimv_top.sv
module vimv_top #(
  parameter int NREGS = vimv_pkg::NREGS_DEF,
  parameter int XLEN  = vimv_pkg::XLEN_DEF,
  localparam int AW   = $clog2(NREGS),
  localparam int LW   = AW + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [AW-1:0]   dst_base,
  input  logic [AW-1:0]   src_base,
  input  logic [AW-1:0]   idx_base,
  input  logic [LW-1:0]   vlen,
  input  logic            zero_neg1,
  output logic            busy,
  output logic            done,
  output logic            trap,
  output logic [AW-1:0]   trap_elem,
  input  logic            tw_en,
  input  logic [AW-1:0]   tw_addr,
  input  logic [XLEN-1:0] tw_data,
  input  logic [AW-1:0]   dbg_addr,
  output logic [XLEN-1:0] dbg_data
);
  logic [AW-1:0]   eng_idx_addr, eng_src_addr, eng_wa;
  logic            eng_we;
  logic [XLEN-1:0] eng_wd;
  logic [AW-1:0]   rf_ra, rf_wa;
  logic [XLEN-1:0] rf_ra_data, rf_rb_data, rf_wd;
  logic            rf_we;

  // Engine owns port A and the write port while busy; test ports otherwise.
  assign rf_ra    = busy ? eng_idx_addr : dbg_addr;
  assign rf_we    = busy ? eng_we : tw_en;
  assign rf_wa    = busy ? eng_wa : tw_addr;
  assign rf_wd    = busy ? eng_wd : tw_data;
  assign dbg_data = rf_ra_data;

  vimv_rf #(.NREGS(NREGS), .XLEN(XLEN)) u_rf (
    .clk     (clk),
    .rst_n   (rst_n),
    .ra_addr (rf_ra),
    .ra_data (rf_ra_data),
    .rb_addr (eng_src_addr),
    .rb_data (rf_rb_data),
    .we      (rf_we),
    .wa      (rf_wa),
    .wd      (rf_wd)
  );

  vimv_seq #(.NREGS(NREGS), .XLEN(XLEN)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .dst_base  (dst_base),
    .src_base  (src_base),
    .idx_base  (idx_base),
    .vlen      (vlen),
    .zero_neg1 (zero_neg1),
    .idx_val   (rf_ra_data),
    .src_val   (rf_rb_data),
    .idx_addr  (eng_idx_addr),
    .src_addr  (eng_src_addr),
    .we        (eng_we),
    .wa        (eng_wa),
    .wd        (eng_wd),
    .busy      (busy),
    .done      (done),
    .trap      (trap),
    .trap_elem (trap_elem)
  );
endmodule

// File: rtl/vimv_chk.sv
module vimv_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic busy,
  input logic done,
  input logic trap,
  input logic eng_we
);
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10

  AST_TRAP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (trap && !start) |=> trap); // R10

  AST_NO_TRAP_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !trap); // R10

  AST_TRAP_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trap) |-> done); // R4

  AST_BUSY_END_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done); // R2

  AST_ENG_WR_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    eng_we |-> busy); // R11

  AST_BUSY_START_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !done) |=> (busy || done)); // R9
endmodule

bind vimv_top vimv_chk u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .start  (start),
  .busy   (busy),
  .done   (done),
  .trap   (trap),
  .eng_we (eng_we)
);

// File: tb/vimv_top_tb.sv
`timescale 1ns/1ps
module vimv_top_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [4:0]  dst_base, src_base, idx_base;
  logic [5:0]  vlen;
  logic        zero_neg1;
  logic        busy, done, trap;
  logic [4:0]  trap_elem;
  logic        tw_en;
  logic [4:0]  tw_addr;
  logic [63:0] tw_data;
  logic [4:0]  dbg_addr;
  logic [63:0] dbg_data;

  int checks = 0;
  int fails  = 0;
  localparam logic [63:0] SENT = 64'hDEAD_BEEF_0000_0000;

  always #2.5 clk = ~clk;

  vimv_top u_dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .dst_base(dst_base), .src_base(src_base), .idx_base(idx_base),
    .vlen(vlen), .zero_neg1(zero_neg1),
    .busy(busy), .done(done), .trap(trap), .trap_elem(trap_elem),
    .tw_en(tw_en), .tw_addr(tw_addr), .tw_data(tw_data),
    .dbg_addr(dbg_addr), .dbg_data(dbg_data)
  );

  function automatic logic [63:0] sval(int k);
    return 64'hA5A5_0000_0000_0000 | 64'(k * 17 + 3);
  endfunction

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(int a, logic [63:0] d);
    @(negedge clk);
    tw_en = 1'b1; tw_addr = 5'(a); tw_data = d;
    @(negedge clk);
    tw_en = 1'b0;
  endtask

  task automatic rd(int a, output logic [63:0] d);
    @(negedge clk);
    dbg_addr = 5'(a);
    #1 d = dbg_data;
  endtask

  task automatic load_src();
    for (int k = 0; k < 8; k++) wr(k, sval(k));
  endtask

  // Issue a request; cyc = negedges from start acceptance until done is seen.
  task automatic run_op(int d, int s, int x, int vl, bit z, output int cyc);
    @(negedge clk);
    dst_base = 5'(d); src_base = 5'(s); idx_base = 5'(x);
    vlen = 6'(vl); zero_neg1 = z; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    while (!done && cyc < 80) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic t_reset();
    logic [63:0] v;
    chk("R1", "busy", 64'(busy), 0);
    chk("R1", "done", 64'(done), 0);
    chk("R1", "trap", 64'(trap), 0);
    chk("R1", "trap_elem", 64'(trap_elem), 0);
    rd(5, v);  chk("R1", "r5", v, 0);
    rd(31, v); chk("R1", "r31", v, 0);
  endtask

  task automatic t_permute();
    int cyc; logic [63:0] v;
    int ix[4] = '{3, 0, 2, 1};
    load_src();
    for (int i = 0; i < 4; i++) wr(8 + i, 64'(ix[i]));
    run_op(16, 0, 8, 4, 1'b0, cyc);
    chk("R2", "latency", 64'(cyc), 5);
    chk("R2", "trap", 64'(trap), 0);
    for (int i = 0; i < 4; i++) begin
      rd(16 + i, v); chk("R2", "dest", v, sval(ix[i]));
    end
  endtask

  task automatic t_dup();
    int cyc; logic [63:0] v;
    int ix[7] = '{5, 5, 3, 3, 4, 4, 4};
    for (int i = 0; i < 7; i++) wr(8 + i, 64'(ix[i]));
    run_op(20, 0, 8, 7, 1'b0, cyc);
    chk("R3", "latency", 64'(cyc), 8);
    for (int i = 0; i < 7; i++) begin
      rd(20 + i, v); chk("R3", "dest", v, sval(ix[i]));
    end
  endtask

  task automatic t_trap_mid();
    int cyc; logic [63:0] v;
    int ix[4] = '{1, 2, 4, 0};
    for (int i = 0; i < 4; i++) begin wr(8 + i, 64'(ix[i])); wr(16 + i, SENT); end
    run_op(16, 0, 8, 4, 1'b0, cyc);
    chk("R4", "latency", 64'(cyc), 4);
    chk("R4", "trap", 64'(trap), 1);
    chk("R4", "trap_elem", 64'(trap_elem), 2);
    rd(16, v); chk("R4", "kept0", v, sval(1));
    rd(17, v); chk("R4", "kept1", v, sval(2));
    rd(18, v); chk("R4", "unwritten2", v, SENT);
    rd(19, v); chk("R4", "unwritten3", v, SENT);
    // trap is held until the next accepted start
    repeat (3) @(negedge clk);
    chk("R10", "trap held", 64'(trap), 1);
    chk("R10", "done pulse", 64'(done), 0);
  endtask

  task automatic t_neg1();
    int cyc; logic [63:0] v;
    wr(8, 0); wr(9, '1); wr(10, 1);
    wr(24, SENT); wr(25, SENT); wr(26, SENT);
    run_op(24, 0, 8, 3, 1'b1, cyc);
    chk("R10", "trap cleared", 64'(trap), 0);
    chk("R5", "latency zero", 64'(cyc), 4);
    rd(24, v); chk("R5", "e0", v, sval(0));
    rd(25, v); chk("R5", "zeroed", v, 0);
    rd(26, v); chk("R5", "e2", v, sval(1));
    wr(25, SENT); wr(26, SENT);
    run_op(24, 0, 8, 3, 1'b0, cyc);
    chk("R5", "trap no enable", 64'(trap), 1);
    chk("R5", "trap_elem", 64'(trap_elem), 1);
    rd(25, v); chk("R5", "not written", v, SENT);
    rd(26, v); chk("R5", "later not written", v, SENT);
  endtask

  task automatic t_bounds();
    int cyc; logic [63:0] v;
    bit saw_busy;
    for (int i = 0; i < 4; i++) wr(8 + i, 64'(i));
    wr(30, SENT);
    @(negedge clk);
    dst_base = 5'd30; src_base = 5'd0; idx_base = 5'd8; vlen = 6'd4;
    zero_neg1 = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    saw_busy = busy;
    chk("R6", "done at 1", 64'(done), 1);
    chk("R6", "trap", 64'(trap), 1);
    chk("R6", "trap_elem", 64'(trap_elem), 0);
    chk("R6", "no busy", 64'(saw_busy), 0);
    rd(30, v); chk("R6", "r30 untouched", v, SENT);
    run_op(28, 0, 8, 4, 1'b0, cyc);
    chk("R6", "exact fit trap", 64'(trap), 0);
    chk("R6", "exact fit latency", 64'(cyc), 5);
    rd(31, v); chk("R6", "r31", v, sval(3));
    run_op(0, 0, 0, 33, 1'b0, cyc);
    chk("R6", "length 33 trap", 64'(trap), 1);
  endtask

  task automatic t_vl0();
    int cyc; logic [63:0] v;
    wr(16, SENT);
    run_op(16, 0, 8, 0, 1'b0, cyc);
    chk("R7", "latency", 64'(cyc), 1);
    chk("R7", "trap", 64'(trap), 0);
    rd(16, v); chk("R7", "no write", v, SENT);
  endtask

  task automatic t_overlap();
    int cyc; logic [63:0] v;
    wr(8, 0); wr(9, 1); wr(10, 2);
    wr(12, 64'h1234_5678); wr(13, 1); wr(14, 2); wr(15, 3);
    run_op(13, 12, 8, 3, 1'b0, cyc);
    for (int i = 0; i < 3; i++) begin
      rd(13 + i, v); chk("R8", "chain", v, 64'h1234_5678);
    end
  endtask

  task automatic t_busy_start();
    int cyc; logic [63:0] v;
    int dones;
    for (int i = 0; i < 4; i++) wr(8 + i, 64'(i));
    wr(24, SENT); wr(31, SENT);
    @(negedge clk);
    dst_base = 5'd16; src_base = 5'd0; idx_base = 5'd8; vlen = 6'd4;
    zero_neg1 = 1'b0; start = 1'b1;
    @(negedge clk);
    dst_base = 5'd24; vlen = 6'd1;
    tw_en = 1'b1; tw_addr = 5'd31; tw_data = 64'h5555;
    chk("R9", "busy", 64'(busy), 1);
    @(negedge clk);
    start = 1'b0; tw_en = 1'b0;
    dones = 0; cyc = 2;
    while (!done && cyc < 80) begin @(negedge clk); cyc++; end
    chk("R9", "latency", 64'(cyc), 5);
    repeat (4) begin @(negedge clk); if (done) dones++; end
    chk("R9", "single done", 64'(dones), 0);
    rd(24, v); chk("R9", "second ignored", v, SENT);
    rd(31, v); chk("R11", "tw ignored busy", v, SENT);
    rd(19, v); chk("R11", "idle read", v, sval(3));
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; tw_en = 1'b0; tw_addr = '0; tw_data = '0;
    dbg_addr = '0; dst_base = '0; src_base = '0; idx_base = '0;
    vlen = '0; zero_neg1 = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_permute();
    t_dup();
    t_trap_mid();
    t_neg1();
    t_bounds();
    t_vl0();
    t_overlap();
    t_busy_start();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule